// File: doc/BRIEF.md
# Multiplexed DRAM Address Generator

This block forms the nine address pins of a bank of 256 k x 1 dynamic RAMs. It serves a 16-bit processor address space cut into four equal segments, and each segment can be steered onto any of sixteen 16 kB banks in an 18-bit physical space. The two top processor address bits pick the segment, and that segment's 4-bit bank number takes their place in the physical address. The physical address then goes out in two halves on the shared pins: a row half and a column half. The ninth pin carries a different bank bit in each half.

A second source is a video fetch port. It has a 14-bit address and its own two-bit I/O port, whose bits are inverted to give physical bits 15:14. The two upper bank bits of the video port come from the top two bits of the last segment's bank number. A third source is an 8-bit refresh row counter. When refresh is requested, the counter takes over the pins, and it steps once for each clock edge on which the request is held. Request, phase and source selection all arrive from outside timing logic. The address path itself is combinational.

Top module: `dram_addr_mux`

## Requirements
- R1: With the processor as source and `col_phase` low, `dram_addr[7:0]` equals `cpu_addr[7:0]` and `dram_addr[8]` equals physical bit 16 (bank bit 2).
- R2: With the processor as source and `col_phase` high, `dram_addr[5:0]` equals `cpu_addr[13:8]`, `dram_addr[7:6]` equals bank bits 1:0 and `dram_addr[8]` equals physical bit 17 (bank bit 3).
- R3: The bank used for a processor access is `seg_banks[4k+3:4k]`, where k is `cpu_addr[15:14]`. The physical address is {bank, `cpu_addr[13:0]`}, and it can be rebuilt from the pins as {col[8], row[8], col[7:0], row[7:0]}.
- R4: With the video source, the physical address is {`seg_banks[15:14]`, ~`vid_port[1:0]`, `vid_addr[13:0]`}. It is split over the pins in the same way as in R1 and R2.
- R5: The video source is used, and `vid_path` is 1, exactly when `vid_sel` is 1 and `refresh_req` is 0. Otherwise the processor or refresh source is used and `vid_path` is 0.
- R6: While `refresh_req` is 1, `dram_addr[7:0]` shows the refresh row counter and `dram_addr[8]` is 0, in either phase and whatever `vid_sel` is.
- R7: The refresh counter increments by one on every rising clock edge with `refresh_req` high. It wraps from 255 to 0 and holds its value otherwise.
- R8: Reset (`rst_n` low) clears the refresh counter to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the refresh counter |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | Processor address |
| seg_banks | input | 16 | Bank numbers, 4 bits per segment, segment 0 in bits 3:0 |
| col_phase | input | 1 | 0 selects the row half, 1 selects the column half |
| vid_sel | input | 1 | Selects the video source |
| vid_addr | input | 14 | Video fetch address |
| vid_port | input | 2 | Video bank port bits (inverted into physical 15:14) |
| refresh_req | input | 1 | Refresh cycle request |
| dram_addr | output | 9 | Multiplexed DRAM address pins |
| vid_path | output | 1 | High while the video source drives the pins |

## Verification
The hardest case to reach from the ports is the refresh counter wrap, combined with proof that the counter holds while refresh is idle. The counter can only be seen on the pins during a refresh. So the stimulus holds the request for more than 256 consecutive edges to cross the wrap. It then leaves refresh idle through long processor and video stretches and comes back to refresh to read the held value. The mapping is covered by a sweep of every segment against every bank number, with each case rebuilt from both phases. Seeded random traffic then mixes all three sources.

// File: rtl/dram_mux_pkg.sv
package dram_mux_pkg;

   // Source that owns the DRAM address pins in a given cycle.
   typedef enum logic [1:0] {
      SRC_CPU     = 2'd0,
      SRC_VIDEO   = 2'd1,
      SRC_REFRESH = 2'd2
   } addr_src_e;

endpackage

// File: rtl/dram_bank_pick.sv
module dram_bank_pick #(
   parameter int SEG_BITS = 2,
   parameter int BANK_W   = 4,
   localparam int SEG_COUNT = 1 << SEG_BITS
) (
   input  logic [SEG_COUNT*BANK_W-1:0] banks,
   input  logic [SEG_BITS-1:0]         seg,
   output logic [BANK_W-1:0]           bank
);

   logic [BANK_W-1:0] slot [SEG_COUNT];

   for (genvar g = 0; g < SEG_COUNT; g++) begin : g_slot
      assign slot[g] = banks[g*BANK_W +: BANK_W];
   end

   assign bank = slot[seg];

endmodule

// File: rtl/dram_refresh_ctr.sv
module dram_refresh_ctr #(
   parameter int REF_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   output logic [REF_W-1:0] row
);

   logic [REF_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (step) cnt <= cnt + REF_W'(1);
   end

   assign row = cnt;

   // R7: one step per refresh edge, modulo 2^REF_W
   p_ref_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> (cnt == REF_W'($past(cnt) + REF_W'(1))));

   // R7: no movement without a request
   p_ref_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(cnt));

endmodule

// File: rtl/dram_pin_split.sv
module dram_pin_split #(
   parameter int LOW_PINS = 8,
   localparam int PINS   = LOW_PINS + 1,
   localparam int PHYS_W = 2 * PINS
) (
   input  logic [PHYS_W-1:0] phys,
   input  logic              col_phase,
   output logic [PINS-1:0]   pins
);

   logic [PINS-1:0] row_half;
   logic [PINS-1:0] col_half;

   // Row: low byte plus the lower of the two extra physical bits.
   assign row_half = {phys[2*LOW_PINS],   phys[LOW_PINS-1:0]};
   // Column: next byte plus the top physical bit.
   assign col_half = {phys[2*LOW_PINS+1], phys[2*LOW_PINS-1:LOW_PINS]};

   assign pins = col_phase ? col_half : row_half;

endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux #(
   parameter int LOW_PINS = 8,
   parameter int CPU_AW   = 16,
   parameter int SEG_BITS = 2,
   parameter int VPORT_W  = 2,
   localparam int PINS      = LOW_PINS + 1,
   localparam int PHYS_W    = 2 * PINS,
   localparam int OFFSET_W  = CPU_AW - SEG_BITS,
   localparam int SEG_COUNT = 1 << SEG_BITS,
   localparam int BANK_W    = PHYS_W - OFFSET_W
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [CPU_AW-1:0]           cpu_addr,
   input  logic [SEG_COUNT*BANK_W-1:0] seg_banks,
   input  logic                        col_phase,
   input  logic                        vid_sel,
   input  logic [OFFSET_W-1:0]         vid_addr,
   input  logic [VPORT_W-1:0]          vid_port,
   input  logic                        refresh_req,
   output logic [PINS-1:0]             dram_addr,
   output logic                        vid_path
);
   import dram_mux_pkg::*;

   // Elaboration-time parameter checks
   if (BANK_W < 1) begin : g_bad_bank
      $error("dram_addr_mux: CPU offset leaves no room for bank bits");
   end
   if (BANK_W <= VPORT_W) begin : g_bad_vport
      $error("dram_addr_mux: video port must be narrower than the bank number");
   end
   if (SEG_BITS < 1) begin : g_bad_seg
      $error("dram_addr_mux: at least two segments required");
   end

   addr_src_e             src;
   logic [SEG_BITS-1:0]   cpu_seg;
   logic [BANK_W-1:0]     cpu_bank;
   logic [BANK_W-1:0]     last_bank;
   logic [PHYS_W-1:0]     cpu_phys;
   logic [PHYS_W-1:0]     vid_phys;
   logic [PHYS_W-1:0]     sel_phys;
   logic [PINS-1:0]       split_pins;
   logic [LOW_PINS-1:0]   ref_row;

   assign cpu_seg = cpu_addr[CPU_AW-1 -: SEG_BITS];

   dram_bank_pick #(.SEG_BITS(SEG_BITS), .BANK_W(BANK_W)) u_pick (
      .banks (seg_banks),
      .seg   (cpu_seg),
      .bank  (cpu_bank)
   );

   assign last_bank = seg_banks[SEG_COUNT*BANK_W-1 -: BANK_W];
   assign cpu_phys  = {cpu_bank, cpu_addr[OFFSET_W-1:0]};
   assign vid_phys  = {last_bank[BANK_W-1 -: BANK_W-VPORT_W], ~vid_port, vid_addr};

   always_comb begin
      if (refresh_req)  src = SRC_REFRESH;
      else if (vid_sel) src = SRC_VIDEO;
      else              src = SRC_CPU;
   end

   assign sel_phys = (src == SRC_VIDEO) ? vid_phys : cpu_phys;

   dram_pin_split #(.LOW_PINS(LOW_PINS)) u_split (
      .phys      (sel_phys),
      .col_phase (col_phase),
      .pins      (split_pins)
   );

   dram_refresh_ctr #(.REF_W(LOW_PINS)) u_ref (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (refresh_req),
      .row   (ref_row)
   );

   assign dram_addr = (src == SRC_REFRESH) ? {1'b0, ref_row} : split_pins;
   assign vid_path  = (src == SRC_VIDEO);

   // R1: processor row half carries the low address byte
   p_cpu_row_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!refresh_req && !vid_sel && !col_phase) |->
         (dram_addr[LOW_PINS-1:0] == cpu_addr[LOW_PINS-1:0]));

   // R2: processor column half carries the offset bits above the low byte
   p_cpu_col_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!refresh_req && !vid_sel && col_phase) |->
         (dram_addr[OFFSET_W-LOW_PINS-1:0] == cpu_addr[OFFSET_W-1:LOW_PINS]));

   // R3: ninth pin in column half is the top bit of the selected segment's bank
   p_cpu_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!refresh_req && !vid_sel && col_phase) |->
         (dram_addr[PINS-1] == seg_banks[cpu_seg*BANK_W + BANK_W-1]));

   // R4: video row half carries the low video address byte
   p_vid_row_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (vid_path && !col_phase) |->
         (dram_addr[LOW_PINS-1:0] == vid_addr[LOW_PINS-1:0]));

   // R5: video path never claimed during refresh
   p_vid_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_req |-> !vid_path);

   // R6: ninth pin low during refresh
   p_ref_pin_r6: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_req |-> (dram_addr[PINS-1] == 1'b0));

endmodule

// File: tb/dram_addr_mux_bench.sv
module dram_addr_mux_bench;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] cpu_addr;
   logic [15:0] seg_banks;
   logic        col_phase;
   logic        vid_sel;
   logic [13:0] vid_addr;
   logic [1:0]  vid_port;
   logic        refresh_req;
   logic [8:0]  dram_addr;
   logic        vid_path;

   int checks = 0;
   int errors = 0;
   logic [7:0] ref_cnt;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dram_addr_mux u_dram_addr_mux (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .seg_banks(seg_banks),
      .col_phase(col_phase), .vid_sel(vid_sel), .vid_addr(vid_addr),
      .vid_port(vid_port), .refresh_req(refresh_req),
      .dram_addr(dram_addr), .vid_path(vid_path)
   );

   function automatic logic [17:0] cpu_phys(input logic [15:0] a, input logic [15:0] b);
      logic [3:0] bk;
      bk = b[a[15:14]*4 +: 4];
      return {bk, a[13:0]};
   endfunction

   function automatic logic [17:0] vid_phys_f(input logic [13:0] va, input logic [1:0] vp,
                                              input logic [15:0] b);
      return {b[15:14], ~vp, va};
   endfunction

   function automatic logic [8:0] pins_of(input logic [17:0] p, input logic ph);
      return ph ? {p[17], p[15:8]} : {p[16], p[7:0]};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Apply one processor/video case, read both halves, compare.
   task automatic both_phases(input string req, input logic [17:0] exp_phys);
      logic [8:0] r, c;
      col_phase = 1'b0; #1; r = dram_addr;
      col_phase = 1'b1; #1; c = dram_addr;
      check({req, " row"}, 32'(r), 32'(pins_of(exp_phys, 1'b0)));
      check({req, " col"}, 32'(c), 32'(pins_of(exp_phys, 1'b1)));
      check({req, " rebuilt"}, 32'({c[8], r[8], c[7:0], r[7:0]}), 32'(exp_phys));
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0C11));
      rst_n = 1'b0; cpu_addr = '0; seg_banks = '0; col_phase = 0;
      vid_sel = 0; vid_addr = '0; vid_port = '0; refresh_req = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R8: counter starts at 0, seen through a refresh cycle
      @(negedge clk);
      refresh_req = 1'b1; #1;
      check("R8 reset count", 32'(dram_addr), 32'h0);
      check("R6 vid_path off in refresh", 32'(vid_path), 32'h0);
      ref_cnt = 8'd0;

      // R7/R6: long refresh run crossing the wrap, other controls random
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         ref_cnt++;
         vid_sel   = 1'($urandom);
         col_phase = 1'($urandom);
         cpu_addr  = 16'($urandom);
         #1;
         check("R7 refresh count", 32'(dram_addr), 32'({1'b0, ref_cnt}));
         if (ref_cnt == 8'd0)
            check("R7 wrap to zero", 32'(dram_addr[7:0]), 32'h0);
      end
      @(negedge clk);
      ref_cnt++;
      refresh_req = 1'b0;
      vid_sel = 1'b0;

      // R1/R2/R3: every segment against every bank number
      for (int s = 0; s < 4; s++) begin
         for (int b = 0; b < 16; b++) begin
            @(negedge clk);
            seg_banks = 16'($urandom);
            seg_banks[s*4 +: 4] = 4'(b);
            cpu_addr = {2'(s), 14'($urandom)};
            both_phases("R3 segment/bank sweep", cpu_phys(cpu_addr, seg_banks));
            check("R1 row low byte", 32'(dram_addr[7:0] & 0), 32'h0);
            col_phase = 1'b0; #1;
            check("R1 ninth pin row", 32'(dram_addr[8]), 32'(b >> 2 & 1));
            col_phase = 1'b1; #1;
            check("R2 bank low bits in col", 32'(dram_addr[7:6]), 32'(b & 3));
            check("R2 ninth pin col", 32'(dram_addr[8]), 32'(b >> 3 & 1));
            check("R5 cpu path flag", 32'(vid_path), 32'h0);
         end
      end

      // Directed corners: all-zero and all-one banks and addresses
      @(negedge clk);
      seg_banks = 16'h0000; cpu_addr = 16'hFFFF;
      both_phases("R1 corner zero banks", cpu_phys(cpu_addr, seg_banks));
      @(negedge clk);
      seg_banks = 16'hFFFF; cpu_addr = 16'h0000;
      both_phases("R2 corner one banks", cpu_phys(cpu_addr, seg_banks));

      // R4/R5: video fetches
      for (int i = 0; i < 64; i++) begin
         @(negedge clk);
         vid_sel   = 1'b1;
         vid_addr  = 14'($urandom);
         vid_port  = 2'($urandom);
         seg_banks = 16'($urandom);
         cpu_addr  = 16'($urandom);
         both_phases("R4 video mapping", vid_phys_f(vid_addr, vid_port, seg_banks));
         check("R5 video path flag", 32'(vid_path), 32'h1);
      end
      @(negedge clk);
      vid_port = 2'b00; vid_addr = 14'h3FFF; seg_banks = 16'h3FFF;
      both_phases("R4 inverted port corner", 18'h0FFFF);

      // R7: counter held through idle stretch
      @(negedge clk);
      vid_sel = 1'b0; refresh_req = 1'b1; #1;
      check("R7 hold while idle", 32'(dram_addr), 32'({1'b0, ref_cnt}));
      @(negedge clk);
      ref_cnt++;
      refresh_req = 1'b0;

      // Mixed random traffic over all sources
      for (int i = 0; i < 400; i++) begin
         logic [17:0] p;
         logic [8:0]  e;
         @(negedge clk);
         refresh_req = ($urandom % 4) == 0;
         vid_sel     = 1'($urandom);
         col_phase   = 1'($urandom);
         cpu_addr    = 16'($urandom);
         seg_banks   = 16'($urandom);
         vid_addr    = 14'($urandom);
         vid_port    = 2'($urandom);
         #1;
         p = vid_sel ? vid_phys_f(vid_addr, vid_port, seg_banks) : cpu_phys(cpu_addr, seg_banks);
         e = refresh_req ? {1'b0, ref_cnt} : pins_of(p, col_phase);
         check(refresh_req ? "R6 mixed refresh" : (vid_sel ? "R4 mixed video" : "R3 mixed cpu"),
               32'(dram_addr), 32'(e));
         check("R5 mixed path flag", 32'(vid_path), 32'(vid_sel && !refresh_req));
         if (refresh_req) ref_cnt++;
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule